// File: doc/BRIEF.md
# Toggle-Advanced Read Prefetch Buffer

This block is a four-entry buffer of 32-bit words that sits between a target-side data bus and a host-side data bus. It never sees a bus handshake. Its only controls are two small command codes, one for the fill side and one for the drain side. A command either restarts its side at entry 0, repeats work on the current entry, or moves on to the next entry.

Stepping forward happens only when the command switches between its two alternating codes, A and B. While the fill controller is still waiting for the target to confirm a word, it keeps issuing the same code. The incoming word is then captured into the same entry on every cycle, so the last capture is the one that counts. When the controller changes code, the pointer moves on. The drain side works the same way. A word can be driven to the host several times, for example once for each of four byte reads. A read can also be issued before the entry it reads is known to be good.

Top module: `toggle_prefetch_buf`

## Requirements
- R1: While `rst` is high, and on the first low-side sample after it, `fill_slot` and `drain_slot` are 0, `host_data` is 0 and every entry is 0. Both sides also forget their previous command.
- R2: Fill code 01 (first) writes `fill_data` into entry 0 and sets `fill_slot` to 0. This happens on every cycle the code is held, so the last value written is the one kept.
- R3: A fill code of 10 (A) or 11 (B) that equals the last non-idle fill code writes `fill_data` again into the entry at `fill_slot`. The pointer does not move.
- R4: A fill code of A or B that differs from a previous non-idle fill code first, A or B moves `fill_slot` forward by one, wrapping from 3 to 0, and writes the data there. An A or B code with no earlier non-idle code since reset writes at the current slot.
- R5: Fill code 00 (idle) writes nothing and leaves `fill_slot` unchanged. It also leaves the remembered fill code unchanged, so the sequence A, idle, A stays on one entry.
- R6: Drain code 01 sets `drain_slot` to 0. One cycle after the command, `host_data` shows entry 0.
- R7: A drain code of A or B equal to the last non-idle drain code keeps `drain_slot` and drives the same entry again on `host_data`, one cycle later.
- R8: A drain code of A or B differing from a previous non-idle drain code moves `drain_slot` forward by one, wrapping modulo 4, and drives that entry one cycle later.
- R9: Drain code 00 holds `host_data`, `drain_slot` and the remembered drain code.
- R10: When a drain command reads the entry that a fill command writes in the same cycle, `host_data` shows the contents from before that write.
- R11: The fill and drain sides run independently under any mix of their commands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fill_cmd | input | 2 | Fill command: 00 idle, 01 first, 10 A, 11 B |
| fill_data | input | 32 | Word from the target-side bus |
| drain_cmd | input | 2 | Drain command: 00 idle, 01 first, 10 A, 11 B |
| host_data | output | 32 | Registered word driven to the host side |
| fill_slot | output | 2 | Entry most recently written |
| drain_slot | output | 2 | Entry most recently read |

## Verification
The hardest case to reach from the ports is a drain command that reads exactly the entry being rewritten in the same cycle. The two sides must line up on one slot through their own separate toggle histories. Directed sequences steer both pointers onto the same entry, with the fill side repeating its code while the drain side re-drives. Seeded random command pairs then hit the collision again from many different pointer histories. Each step is compared against a bench model that applies the read-before-write rule.

// File: rtl/tpb_pkg.sv
package tpb_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_FIRST = 2'b01,
        CMD_A     = 2'b10,
        CMD_B     = 2'b11
    } tpb_cmd_e;

    typedef struct packed {
        logic       en;
        logic [1:0] code;
    } tpb_cmd_s;

    function automatic tpb_cmd_s to_cmd(input logic [1:0] raw);
        tpb_cmd_s c;
        c.code = raw;
        c.en   = (raw != CMD_IDLE);
        return c;
    endfunction

    // True when an alternating code follows a different non-idle code
    function automatic logic is_toggle(input logic [1:0] cur, input logic [1:0] prev);
        return (cur == CMD_A || cur == CMD_B) && (prev != CMD_IDLE) && (cur != prev);
    endfunction

endpackage

// File: rtl/tpb_cmd_track.sv
module tpb_cmd_track
    import tpb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cmd,
    output logic             act,
    output logic [PTR_W-1:0] slot,
    output logic [PTR_W-1:0] ptr_q
);

    tpb_cmd_s        cur;
    logic [1:0]      last_q;
    logic [PTR_W-1:0] ptr_inc;

    assign cur = to_cmd(cmd);
    assign act = cur.en;

    always_comb begin
        if (ptr_q == PTR_W'(DEPTH - 1)) ptr_inc = '0;
        else                            ptr_inc = ptr_q + 1'b1;
    end

    always_comb begin
        slot = ptr_q;
        if (cur.code == CMD_FIRST)            slot = '0;
        else if (is_toggle(cur.code, last_q)) slot = ptr_inc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            last_q <= CMD_IDLE;
        end else if (cur.en) begin
            ptr_q  <= slot;
            last_q <= cur.code;
        end
    end

    assert_first_home_R2: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_FIRST |=> ptr_q == '0);

    assert_repeat_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_A || cmd == CMD_B) && cmd == last_q |=> $stable(ptr_q));

    assert_toggle_steps_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_A || cmd == CMD_B) && last_q != CMD_IDLE && cmd != last_q
        |=> ptr_q == (($past(ptr_q) == PTR_W'(DEPTH - 1)) ? '0 : $past(ptr_q) + 1'b1));

    assert_idle_freeze_R5: assert property (@(posedge clk) disable iff (rst)
        cmd == CMD_IDLE |=> $stable(ptr_q) && $stable(last_q));

endmodule

// File: rtl/tpb_store.sv
module tpb_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_slot,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [PTR_W-1:0]  rd_slot,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            always_ff @(posedge clk) begin
                if (rst)                                 mem[i] <= '0;
                else if (wr_en && wr_slot == PTR_W'(i))  mem[i] <= wr_data;
            end
        end
    endgenerate

    // Read returns contents present before this edge's write
    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_slot];
    end

    assert_drain_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    assert_read_before_write_R10: assert property (@(posedge clk) disable iff (rst)
        rd_en && wr_en && rd_slot == wr_slot |=> rd_data == $past(mem[rd_slot]));

endmodule

// File: rtl/toggle_prefetch_buf.sv
module toggle_prefetch_buf
    import tpb_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        fill_cmd,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [1:0]        drain_cmd,
    output logic [DATA_W-1:0] host_data,
    output logic [PTR_W-1:0]  fill_slot,
    output logic [PTR_W-1:0]  drain_slot
);

    logic             f_act, d_act;
    logic [PTR_W-1:0] f_slot, d_slot;

    tpb_cmd_track #(.DEPTH(DEPTH)) u_fill (
        .clk(clk), .rst(rst), .cmd(fill_cmd),
        .act(f_act), .slot(f_slot), .ptr_q(fill_slot)
    );

    tpb_cmd_track #(.DEPTH(DEPTH)) u_drain (
        .clk(clk), .rst(rst), .cmd(drain_cmd),
        .act(d_act), .slot(d_slot), .ptr_q(drain_slot)
    );

    tpb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst(rst),
        .wr_en(f_act), .wr_slot(f_slot), .wr_data(fill_data),
        .rd_en(d_act), .rd_slot(d_slot), .rd_data(host_data)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> fill_slot == '0 && drain_slot == '0 && host_data == '0);

    assert_drain_first_R6: assert property (@(posedge clk) disable iff (rst)
        drain_cmd == CMD_FIRST |=> drain_slot == '0);

endmodule

// File: tb/tb_toggle_prefetch_buf.sv
module tb_toggle_prefetch_buf;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  fill_cmd, drain_cmd;
    logic [31:0] fill_data;
    logic [31:0] host_data;
    logic [1:0]  fill_slot, drain_slot;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] m_mem [4];
    logic [1:0]  m_wp, m_rp, m_lf, m_ld;
    logic [31:0] m_hd;

    always #4 clk = ~clk;

    toggle_prefetch_buf dut (
        .clk(clk), .rst(rst), .fill_cmd(fill_cmd), .fill_data(fill_data),
        .drain_cmd(drain_cmd), .host_data(host_data),
        .fill_slot(fill_slot), .drain_slot(drain_slot)
    );

    function automatic logic [1:0] nxt(input logic [1:0] c, input logic [1:0] last,
                                       input logic [1:0] p);
        if (c == 2'b01) return 2'd0;
        if (c == 2'b00) return p;
        if (last != 2'b00 && last != c) return p + 2'd1;
        return p;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "host_data", host_data, m_hd);
        chk(req, "fill_slot", {30'd0, fill_slot}, {30'd0, m_wp});
        chk(req, "drain_slot", {30'd0, drain_slot}, {30'd0, m_rp});
    endtask

    task automatic step(input logic [1:0] fc, input logic [31:0] fd,
                        input logic [1:0] dc, input string req);
        logic [1:0] ft, dt;
        string tag;
        fill_cmd = fc; fill_data = fd; drain_cmd = dc;
        ft = nxt(fc, m_lf, m_wp);
        dt = nxt(dc, m_ld, m_rp);
        tag = req;
        if (fc != 2'b00 && dc != 2'b00 && ft == dt) tag = "R10";
        if (dc != 2'b00) m_hd = m_mem[dt];
        if (fc != 2'b00) begin m_mem[ft] = fd; m_lf = fc; end
        if (dc != 2'b00) m_ld = dc;
        m_wp = ft; m_rp = dt;
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) m_mem[i] = '0;
        m_wp = 0; m_rp = 0; m_lf = 0; m_ld = 0; m_hd = 0;
        rst = 1'b1; fill_cmd = 0; drain_cmd = 0; fill_data = 0;
        repeat (3) @(negedge clk);
        check_all("R1");
        rst = 1'b0;
        void'($urandom(32'd4242));

        // Fill side directed
        step(2'b01, 32'h0000_0011, 2'b00, "R2");
        step(2'b01, 32'h0000_0022, 2'b00, "R2");
        step(2'b10, 32'h0000_0033, 2'b00, "R4");
        step(2'b10, 32'h0000_0044, 2'b00, "R3");
        step(2'b00, 32'h0000_0055, 2'b00, "R5");
        step(2'b10, 32'h0000_0066, 2'b00, "R5");
        step(2'b11, 32'h0000_0077, 2'b00, "R4");
        step(2'b10, 32'h0000_0088, 2'b00, "R4");
        step(2'b11, 32'h0000_0099, 2'b00, "R4");
        // Drain side directed: entry0=99, 1=66, 2=77, 3=88
        step(2'b00, 32'h0, 2'b01, "R6");
        step(2'b00, 32'h0, 2'b01, "R6");
        step(2'b00, 32'h0, 2'b10, "R8");
        step(2'b00, 32'h0, 2'b10, "R7");
        step(2'b00, 32'h0, 2'b10, "R7");
        step(2'b00, 32'h0, 2'b00, "R9");
        step(2'b00, 32'h0, 2'b11, "R8");
        step(2'b00, 32'h0, 2'b10, "R8");
        step(2'b00, 32'h0, 2'b11, "R8");
        // Same-slot collision: both at entry 0, fill repeats, drain re-drives
        step(2'b01, 32'hAAAA_0001, 2'b01, "R10");
        step(2'b01, 32'hAAAA_0002, 2'b01, "R10");
        step(2'b10, 32'hAAAA_0003, 2'b10, "R10");
        step(2'b10, 32'hAAAA_0004, 2'b10, "R10");
        step(2'b00, 32'h0, 2'b10, "R7");

        // Seeded random mix
        for (int n = 0; n < 3000; n++) begin
            step(2'($urandom % 4), $urandom, 2'($urandom % 4), "R11");
            if (n == 1500) begin
                rst = 1'b1;
                for (int i = 0; i < 4; i++) m_mem[i] = '0;
                m_wp = 0; m_rp = 0; m_lf = 0; m_ld = 0; m_hd = 0;
                fill_cmd = 0; drain_cmd = 0;
                @(posedge clk); @(negedge clk);
                check_all("R1");
                rst = 1'b0;
                // Alternating code with no prior command stays at slot 0
                step(2'b11, 32'h1234_5678, 2'b10, "R4");
            end
        end
        done = 1;
    end

    initial begin
        fork
            begin wait (done); end
            begin
                repeat (100000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule